// File: doc/BRIEF.md
# Order-Wire Serial Capture Receiver

This block sits on the receive side of a transport-overhead serial port. It rebuilds the three order-wire overhead bytes that one frame carries: E1, then F1, then E2. The producer sends four signals: a clock, one data bit, a valid qualifier and a one-clock frame marker. The producer changes all of them on the falling clock edge, so this receiver samples them on the rising edge.

Capture begins on the rising edge where the frame marker and valid are both high. That bit is the first bit of E1. From then on the receiver shifts in one bit per edge for as long as valid stays high. The burst ends at the first edge where valid is low. A burst of exactly 24 bits is copied to the three byte outputs, and a one-cycle ready strobe is raised. A burst of any other length is thrown away and sets a sticky length-error flag. That flag stays set until the clear input is asserted.

Top module: `ow_capture_rx`

## Requirements
- R1: Bits are taken on the rising clock edge and assembled most significant bit first. Serial bits 0 to 7 of a burst form E1 (bit 0 is E1 bit 7), bits 8 to 15 form F1, and bits 16 to 23 form E2.
- R2: Capture starts only on an edge where valid and the frame marker are both sampled high. While no capture is running, valid alone or the marker alone is ignored. This includes every valid bit before the first marker after reset.
- R3: While a capture is running, each edge with valid high adds one bit. The first edge with valid low ends the capture.
- R4: If a capture ends with exactly 24 bits collected, the three byte outputs take the new bytes at that ending edge. The ready output is then high for exactly the one following clock cycle.
- R5: If a capture ends with any count other than 24, the partial data is discarded. The byte outputs keep their previous values and no ready strobe is raised.
- R6: A length error (R5) sets len_err. len_err stays high until err_clr is sampled high on a rising edge, and clearing takes effect at that edge.
- R7: A frame marker sampled with valid high in the middle of a burst restarts the count. That bit becomes E1 bit 7 of a new capture.
- R8: While rst_n is sampled low, all byte outputs, ready and len_err go to 0, and any capture is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Overhead clock; inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_bit | input | 1 | Serial order-wire data bit |
| ser_vld | input | 1 | High while ser_bit carries an order-wire bit |
| frm_mark | input | 1 | One-clock marker on the first bit of E1 |
| err_clr | input | 1 | Clears the sticky length error |
| e1_byte | output | 8 | Last complete E1 byte |
| f1_byte | output | 8 | Last complete F1 byte |
| e2_byte | output | 8 | Last complete E2 byte |
| bytes_rdy | output | 1 | One-cycle strobe when new bytes are loaded |
| len_err | output | 1 | Sticky flag: a burst ended with a length other than 24 |

## Verification
The last bit of a burst is sampled at some edge N, and valid is seen low at edge N+1. The byte outputs, ready and len_err all change at edge N+1. Ready falls again at edge N+2. The bench drives every input on the falling edge and reads the outputs on the falling edge that follows the edge where they are due. It reads ready both in its high cycle and one cycle later. A clear request is driven on one falling edge, and its result is read on the next falling edge.

// File: rtl/ow_pkg.sv
// Package: types and constants shared by the order-wire capture receiver.
package ow_pkg;
    // Number of overhead bytes in one frame's order-wire burst.
    localparam int OW_NUM_BYTES = 3;

    // Capture control state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CAPT = 1'b1
    } ow_state_e;
endpackage

// File: rtl/ow_frame_ctrl.sv
// Module: ow_frame_ctrl
// Decides, for each rising edge, whether the sampled bit starts a capture,
// continues one, or ends one.
// Assumes: valid and the marker are already stable at the rising edge
// (the producer launches them on the falling edge).
module ow_frame_ctrl
    import ow_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      vld_i,
    input  logic      fmark_i,
    output logic      shift_en_o,
    output logic      restart_o,
    output logic      burst_end_o,
    output ow_state_e state_o
);
    ow_state_e state_q;
    logic      start_w;

    // Decode the sampled strobes into start, shift and end events.
    always_comb begin
        start_w     = vld_i && fmark_i;
        restart_o   = start_w;
        shift_en_o  = start_w || (state_q == ST_CAPT && vld_i);
        burst_end_o = (state_q == ST_CAPT) && !vld_i;
    end

    // Track whether a capture burst is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (start_w) begin
            state_q <= ST_CAPT;
        end else if (burst_end_o) begin
            state_q <= ST_IDLE;
        end
    end

    assign state_o = state_q;

    AST_END_ON_VLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPT && !vld_i) |=> (state_q == ST_IDLE)); // R3
    AST_MARK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && fmark_i) |=> (state_q == ST_CAPT)); // R2
endmodule

// File: rtl/ow_shift_collector.sv
// Module: ow_shift_collector
// Shifts serial bits in, most significant first, and counts them.
// The count saturates one above the full length, so any over-long burst
// still reads as "not full".
// Assumes: restart and shift_en come from ow_frame_ctrl for the same edge.
module ow_shift_collector #(
    parameter int TOTAL_BITS = 24,
    parameter int CNT_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en_i,
    input  logic                  restart_i,
    input  logic                  bit_i,
    output logic [TOTAL_BITS-1:0] data_o,
    output logic [CNT_W-1:0]      cnt_o
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(TOTAL_BITS + 1);

    logic [TOTAL_BITS-1:0] sreg_q;
    logic [CNT_W-1:0]      cnt_q;

    // Shift in the sampled bit and advance the saturating bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (shift_en_i) begin
            sreg_q <= {sreg_q[TOTAL_BITS-2:0], bit_i};
            if (restart_i) begin
                cnt_q <= CNT_W'(1);
            end else if (cnt_q != CNT_SAT) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign data_o = sreg_q;
    assign cnt_o  = cnt_q;

    AST_RESTART_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == CNT_W'(1))); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_SAT); // R3
endmodule

// File: rtl/ow_out_regs.sv
// Module: ow_out_regs
// Holds the last complete set of bytes and raises the ready strobe.
// Also keeps the sticky length-error flag.
// Assumes: burst_end is high for only one edge per burst, and data and
// count are final on that edge.
module ow_out_regs #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    parameter int CNT_W     = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                burst_end_i,
    input  logic [CNT_W-1:0]                    cnt_i,
    input  logic [NUM_BYTES*BYTE_W-1:0]         data_i,
    input  logic                                err_clr_i,
    output logic [NUM_BYTES-1:0][BYTE_W-1:0]    bytes_o,
    output logic                                rdy_o,
    output logic                                err_o
);
    localparam int TOTAL_BITS = NUM_BYTES * BYTE_W;

    logic [NUM_BYTES*BYTE_W-1:0] word_q;
    logic                        full_w;

    assign full_w = (cnt_i == CNT_W'(TOTAL_BITS));

    // Load bytes and strobe ready when a full-length burst ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            rdy_o  <= 1'b0;
        end else begin
            rdy_o <= burst_end_i && full_w;
            if (burst_end_i && full_w) begin
                word_q <= data_i;
            end
        end
    end

    // Set the sticky error on a wrong length; clear it on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (burst_end_i && !full_w) begin
            err_o <= 1'b1;
        end else if (err_clr_i) begin
            err_o <= 1'b0;
        end
    end

    // Split the word into bytes; the highest slice is the first one sent.
    for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_slice
        assign bytes_o[gi] = word_q[gi*BYTE_W +: BYTE_W];
    end

    AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |=> !rdy_o); // R4
    AST_BYTES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_o |-> $stable(word_q)); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !err_clr_i) |=> err_o); // R6
endmodule

// File: rtl/ow_capture_rx.sv
// Module: ow_capture_rx (top)
// Receives the serial order-wire stream and rebuilds the E1, F1 and E2
// bytes of each frame.
// Assumes: the producer launches its signals on the falling edge, and all
// inputs are synchronous to clk.
module ow_capture_rx
    import ow_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic              ser_vld,
    input  logic              frm_mark,
    input  logic              err_clr,
    output logic [BYTE_W-1:0] e1_byte,
    output logic [BYTE_W-1:0] f1_byte,
    output logic [BYTE_W-1:0] e2_byte,
    output logic              bytes_rdy,
    output logic              len_err
);
    localparam int TOTAL_BITS = OW_NUM_BYTES * BYTE_W;
    localparam int CNT_W      = $clog2(TOTAL_BITS + 2);

    logic                                  shift_en;
    logic                                  restart;
    logic                                  burst_end;
    ow_state_e                             state;
    logic [TOTAL_BITS-1:0]                 data;
    logic [CNT_W-1:0]                      cnt;
    logic [OW_NUM_BYTES-1:0][BYTE_W-1:0]   bytes;

    ow_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .vld_i       (ser_vld),
        .fmark_i     (frm_mark),
        .shift_en_o  (shift_en),
        .restart_o   (restart),
        .burst_end_o (burst_end),
        .state_o     (state)
    );

    ow_shift_collector #(
        .TOTAL_BITS (TOTAL_BITS),
        .CNT_W      (CNT_W)
    ) u_coll (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (shift_en),
        .restart_i  (restart),
        .bit_i      (ser_bit),
        .data_o     (data),
        .cnt_o      (cnt)
    );

    ow_out_regs #(
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (OW_NUM_BYTES),
        .CNT_W     (CNT_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_end_i (burst_end),
        .cnt_i       (cnt),
        .data_i      (data),
        .err_clr_i   (err_clr),
        .bytes_o     (bytes),
        .rdy_o       (bytes_rdy),
        .err_o       (len_err)
    );

    assign e1_byte = bytes[2];
    assign f1_byte = bytes[1];
    assign e2_byte = bytes[0];

    AST_RDY_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        bytes_rdy |-> $past(burst_end && cnt == CNT_W'(TOTAL_BITS))); // R4
    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(ser_vld && frm_mark)) |=> $stable(cnt)); // R2
endmodule

// File: tb/ow_capture_rx_tb.sv
module ow_capture_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b0;
    logic       ser_vld = 1'b0;
    logic       frm_mark = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] e1_byte, f1_byte, e2_byte;
    logic       bytes_rdy, len_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [23:0] last_good = 24'h0;

    always #5 clk = ~clk;

    ow_capture_rx u_dut (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_vld(ser_vld),
        .frm_mark(frm_mark), .err_clr(err_clr), .e1_byte(e1_byte),
        .f1_byte(f1_byte), .e2_byte(e2_byte), .bytes_rdy(bytes_rdy),
        .len_err(len_err)
    );

    // Table entries: {data[23:0], burst length[7:0], expect ready, expect error}
    localparam int NVEC = 6;
    localparam logic [33:0] VEC_TBL [0:NVEC-1] = '{
        {24'hA53C0F, 8'd24, 1'b1, 1'b0},
        {24'hFF0081, 8'd24, 1'b1, 1'b0},
        {24'h123456, 8'd23, 1'b0, 1'b1},
        {24'h654321, 8'd25, 1'b0, 1'b1},
        {24'h800001, 8'd24, 1'b1, 1'b0},
        {24'hDEADBE, 8'd1,  1'b0, 1'b1}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_bytes(input logic [23:0] exp, input string tag);
        check({8'h0, e1_byte, f1_byte, e2_byte}, {8'h0, exp}, tag);
    endtask

    // Sends len bits of data MSB first; a marker goes with the first bit if mark is set.
    task automatic send_burst(input logic [23:0] data, input int len, input logic mark);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ser_vld  = 1'b1;
            frm_mark = mark && (i == 0);
            ser_bit  = (i < 24) ? data[23-i] : 1'b0;
        end
        @(negedge clk);
        ser_vld  = 1'b0;
        frm_mark = 1'b0;
        ser_bit  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<200000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R8: outputs are zero after reset
        @(negedge clk);
        check_bytes(24'h0, "R8 bytes after reset");
        check(bytes_rdy, 0, "R8 ready after reset");
        check(len_err, 0, "R8 error after reset");

        // R2: valid bits before the first marker are ignored
        send_burst(24'hC3C3C3, 30, 1'b0);
        @(negedge clk);
        check(bytes_rdy, 0, "R2 no ready without marker");
        check(len_err, 0, "R2 no error without marker");
        @(negedge clk);
        check_bytes(24'h0, "R2 bytes untouched before marker");

        // R1 R3 R4 R5 R6: table-driven bursts
        for (int v = 0; v < NVEC; v++) begin
            logic [23:0] d;
            int          n;
            logic        er, ee;
            d  = VEC_TBL[v][33:10];
            n  = int'(VEC_TBL[v][9:2]);
            er = VEC_TBL[v][1];
            ee = VEC_TBL[v][0];
            send_burst(d, n, 1'b1);
            @(negedge clk);
            check(bytes_rdy, er, "R4 ready in cycle after end");
            check(len_err, ee, "R5 error flag after end");
            if (er) last_good = d;
            check_bytes(last_good, "R1 R5 byte outputs");
            @(negedge clk);
            check(bytes_rdy, 0, "R4 ready lasts one cycle");
            if (ee) begin
                repeat (3) @(negedge clk);
                check(len_err, 1, "R6 error stays set");
                err_clr = 1'b1;
                @(negedge clk);
                err_clr = 1'b0;
                check(len_err, 0, "R6 error cleared");
            end
        end

        // R7: a marker in mid-burst restarts the capture
        for (int i = 0; i < 34; i++) begin
            @(negedge clk);
            ser_vld  = 1'b1;
            frm_mark = (i == 0) || (i == 10);
            ser_bit  = (i < 10) ? i[0] : 24'h5AC371 >> (23 - (i - 10));
        end
        @(negedge clk);
        ser_vld = 1'b0; frm_mark = 1'b0;
        @(negedge clk);
        check(bytes_rdy, 1, "R7 ready after restarted burst");
        check(len_err, 0, "R7 no error after restart");
        check_bytes(24'h5AC371, "R7 bytes from restart point");
        last_good = 24'h5AC371;

        // R2: a marker without valid, then unmarked valid bits, are ignored
        @(negedge clk);
        frm_mark = 1'b1;
        @(negedge clk);
        frm_mark = 1'b0;
        send_burst(24'h0F0F0F, 24, 1'b0);
        @(negedge clk);
        check(bytes_rdy, 0, "R2 marker without valid ignored");
        check(len_err, 0, "R2 no error for idle bits");
        check_bytes(last_good, "R2 bytes kept while idle");

        // R8: reset in mid-burst abandons the capture
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            ser_vld = 1'b1; frm_mark = (i == 0); ser_bit = 1'b1;
        end
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ser_vld = 1'b0; frm_mark = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(len_err, 0, "R8 no error after reset mid-burst");
        check_bytes(24'h0, "R8 bytes cleared by reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule